// File: doc/BRIEF.md
# Outbound Transfer Tracker with ID-Pair Interlock

The block accepts transfer descriptors into a small in-order queue. Each descriptor carries a byte length, a source ID, a destination ID and a priority. The block takes the oldest descriptor and cuts it into request packets of at most 256 bytes. It offers these packets on a valid/ready output one after another and does not wait for any response between them. Every packet in flight holds a 4-bit tag. Responses come back carrying that tag and free it again. The block starts the next descriptor only after every response of the current transfer has come back. At that point it gives a single-cycle completion pulse, together with an error flag.

Several trackers can share one fabric. Each tracker shows the ID pair it is holding, and each tracker watches one peer. A tracker does not start a descriptor whose ID pair the peer currently holds. A flush command scans the queue over several cycles and drops every waiting descriptor whose source ID matches. The transfer that is already running is not affected.

Top module: `tx_burst_tracker`

## Requirements
- R1: A transfer of L bytes (1 to 1048576) is issued as ceil(L/256) packets. Every packet carries 256 bytes except the last, which carries the remainder. Each packet carries the descriptor's source, destination and priority.
- R2: While `pkt_ready` stays high and tags are free, the packets of one transfer are accepted on consecutive cycles. A packet held back by `pkt_ready` low keeps its tag and byte count stable.
- R3: Tags are handed out in order 0,1,…,15 and wrap to 0. The counting continues across transfers. A packet is not offered while its tag is still in flight, so at most 16 packets are outstanding.
- R4: The next descriptor does not start until every response of the current transfer has arrived. `done` then pulses for exactly one cycle, and `done_err` is high in that cycle if any response of the transfer had `rsp_err` set.
- R5: A response whose tag is not in flight pulses `proto_err` for that cycle. It does not complete any packet and does not bring `done` forward.
- R6: A queued descriptor does not start while `peer_busy` is high with `peer_src`/`peer_dst` equal to its own ID pair. It starts once the peer releases the pair.
- R7: With YIELD=1, a descriptor also does not start in a cycle where `peer_grab` is high with a matching pair. A grab on a different pair does not block it.
- R8: A `flush_req` pulse removes every queued descriptor with source ID `flush_src`. `flush_busy` is high while the scan runs, and `desc_ready` is low during that time. The running transfer is not affected, and the remaining descriptors keep their order.
- R9: Descriptors start in the order they were pushed. `desc_ready` is low while QDEPTH descriptors are waiting.
- R10: After reset, `desc_ready` is high and `pkt_valid`, `hold_busy`, `done` and `flush_busy` are low.
- R11: `hold_grab` pulses for one cycle when a descriptor starts. `hold_busy` stays high from the next cycle until `done`, and `hold_src`/`hold_dst` hold the running pair during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Queue can take a descriptor |
| desc_len | input | LEN_W | Transfer length in bytes |
| desc_src | input | ID_W | Source ID |
| desc_dst | input | ID_W | Destination ID |
| desc_pri | input | PRI_W | Priority |
| flush_req | input | 1 | Start a flush scan |
| flush_src | input | ID_W | Source ID to drop |
| flush_busy | output | 1 | Flush scan in progress |
| pkt_valid | output | 1 | Request packet offered |
| pkt_ready | input | 1 | Downstream accepts packet |
| pkt_tag | output | TAG_W | Packet tag |
| pkt_bytes | output | SEG_W | Packet payload bytes |
| pkt_src | output | ID_W | Packet source ID |
| pkt_dst | output | ID_W | Packet destination ID |
| pkt_pri | output | PRI_W | Packet priority |
| rsp_valid | input | 1 | Response arrives |
| rsp_tag | input | TAG_W | Response tag |
| rsp_err | input | 1 | Response error status |
| done | output | 1 | Transfer complete pulse |
| done_err | output | 1 | Completed transfer saw an error |
| proto_err | output | 1 | Response with unknown tag |
| peer_busy | input | 1 | Peer holds a pair |
| peer_grab | input | 1 | Peer starts this cycle |
| peer_src | input | ID_W | Peer pair source ID |
| peer_dst | input | ID_W | Peer pair destination ID |
| hold_busy | output | 1 | This tracker holds a pair |
| hold_grab | output | 1 | This tracker starts this cycle |
| hold_src | output | ID_W | Held (or about to be held) source ID |
| hold_dst | output | ID_W | Held (or about to be held) destination ID |

## Verification
The hardest state to reach is the flush scan running against a full queue while a transfer is active. The scan must skip the running transfer, remove a matching entry from the middle, and leave the later entries in order. The stimulus reaches this state by holding `pkt_ready` low so that the first transfer cannot finish. It then fills the queue behind it with descriptors that alternate between matching and non-matching source IDs, and only then fires the flush. The 17-packet transfer is a second hard case. It is left without responses until the tag counter has wrapped onto a tag that is still in flight. Only the oldest response is returned, which checks that exactly that tag is reused.

// File: rtl/tx_burst_tracker.sv
module tx_burst_tracker #(
  parameter int ID_W   = 8,
  parameter int PRI_W  = 2,
  parameter int LEN_W  = 21,
  parameter int QDEPTH = 4,
  parameter int SEG    = 256,
  parameter int TAGS   = 16,
  parameter bit YIELD  = 1'b1,
  localparam int TAG_W = $clog2(TAGS),
  localparam int SEG_W = $clog2(SEG) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [LEN_W-1:0] desc_len,
  input  logic [ID_W-1:0]  desc_src,
  input  logic [ID_W-1:0]  desc_dst,
  input  logic [PRI_W-1:0] desc_pri,
  input  logic             flush_req,
  input  logic [ID_W-1:0]  flush_src,
  output logic             flush_busy,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic [TAG_W-1:0] pkt_tag,
  output logic [SEG_W-1:0] pkt_bytes,
  output logic [ID_W-1:0]  pkt_src,
  output logic [ID_W-1:0]  pkt_dst,
  output logic [PRI_W-1:0] pkt_pri,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  input  logic             rsp_err,
  output logic             done,
  output logic             done_err,
  output logic             proto_err,
  input  logic             peer_busy,
  input  logic             peer_grab,
  input  logic [ID_W-1:0]  peer_src,
  input  logic [ID_W-1:0]  peer_dst,
  output logic             hold_busy,
  output logic             hold_grab,
  output logic [ID_W-1:0]  hold_src,
  output logic [ID_W-1:0]  hold_dst
);
  localparam int QI_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNT_W = $clog2(QDEPTH + 1);

  logic [LEN_W-1:0] q_len [QDEPTH];
  logic [ID_W-1:0]  q_src [QDEPTH];
  logic [ID_W-1:0]  q_dst [QDEPTH];
  logic [PRI_W-1:0] q_pri [QDEPTH];
  logic [CNT_W-1:0] count;

  logic             fl_on;
  logic [CNT_W-1:0] fl_idx;
  logic [ID_W-1:0]  fl_src;

  logic             active, err_acc;
  logic [LEN_W-1:0] rem;
  logic [ID_W-1:0]  cur_src, cur_dst;
  logic [PRI_W-1:0] cur_pri;
  logic [TAG_W-1:0] tag_seq;
  logic [TAGS-1:0]  inflight;

  logic pair_hit, conflict, start, push, issue, fl_hit, rm_en, rsp_known;
  logic [QI_W-1:0]  rm_idx, widx;

  assign desc_ready = (count != CNT_W'(QDEPTH)) && !fl_on;
  assign push       = desc_valid && desc_ready;
  assign flush_busy = fl_on;

  assign pair_hit  = (peer_src == q_src[0]) && (peer_dst == q_dst[0]);
  assign conflict  = pair_hit && (peer_busy || (YIELD && peer_grab));
  assign start     = !active && (count != '0) && !fl_on && !conflict;
  assign hold_grab = start;
  assign hold_busy = active;
  assign hold_src  = active ? cur_src : q_src[0];
  assign hold_dst  = active ? cur_dst : q_dst[0];

  assign fl_hit = fl_on && (fl_idx < count) && (q_src[fl_idx[QI_W-1:0]] == fl_src);
  assign rm_en  = start || fl_hit;
  assign rm_idx = fl_hit ? fl_idx[QI_W-1:0] : '0;
  assign widx   = QI_W'(count - CNT_W'(rm_en));

  assign pkt_bytes = (rem > LEN_W'(SEG)) ? SEG_W'(SEG) : rem[SEG_W-1:0];
  assign pkt_valid = active && (rem != '0) && !inflight[tag_seq];
  assign pkt_tag   = tag_seq;
  assign pkt_src   = cur_src;
  assign pkt_dst   = cur_dst;
  assign pkt_pri   = cur_pri;
  assign issue     = pkt_valid && pkt_ready;

  assign rsp_known = rsp_valid && inflight[rsp_tag];
  assign proto_err = rsp_valid && !inflight[rsp_tag];
  assign done      = active && (rem == '0) && (inflight == '0);
  assign done_err  = done && err_acc;

  always_ff @(posedge clk) begin
    for (int i = 0; i < QDEPTH - 1; i++) begin
      if (rm_en && i >= int'(rm_idx)) begin
        q_len[i] <= q_len[i+1];
        q_src[i] <= q_src[i+1];
        q_dst[i] <= q_dst[i+1];
        q_pri[i] <= q_pri[i+1];
      end
    end
    if (push) begin
      q_len[widx] <= desc_len;
      q_src[widx] <= desc_src;
      q_dst[widx] <= desc_dst;
      q_pri[widx] <= desc_pri;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      fl_on    <= 1'b0;
      fl_idx   <= '0;
      fl_src   <= '0;
      active   <= 1'b0;
      err_acc  <= 1'b0;
      rem      <= '0;
      cur_src  <= '0;
      cur_dst  <= '0;
      cur_pri  <= '0;
      tag_seq  <= '0;
      inflight <= '0;
    end else begin
      count <= count + CNT_W'(push) - CNT_W'(rm_en);
      if (!fl_on && flush_req) begin
        fl_on  <= 1'b1;
        fl_idx <= '0;
        fl_src <= flush_src;
      end else if (fl_on) begin
        if (fl_idx >= count) fl_on <= 1'b0;
        else if (!fl_hit)    fl_idx <= fl_idx + 1'b1;
      end
      if (start) begin
        active  <= 1'b1;
        err_acc <= 1'b0;
        rem     <= q_len[0];
        cur_src <= q_src[0];
        cur_dst <= q_dst[0];
        cur_pri <= q_pri[0];
      end else begin
        if (done) active <= 1'b0;
        if (rsp_known && rsp_err) err_acc <= 1'b1;
        if (issue) begin
          rem     <= rem - LEN_W'(pkt_bytes);
          tag_seq <= tag_seq + 1'b1;
        end
      end
      begin
        logic [TAGS-1:0] nx;
        nx = inflight;
        if (rsp_known) nx[rsp_tag] = 1'b0;
        if (issue)     nx[tag_seq] = 1'b1;
        inflight <= nx;
      end
    end
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_pkt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_tag) && $stable(pkt_bytes) && $stable(pkt_src));
  assert_last_short_R1: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (pkt_bytes < SEG_W'(SEG)) |=> !pkt_valid);
  assert_hold_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy && !done |=> hold_busy && $stable(hold_src) && $stable(hold_dst));
  assert_scan_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fl_on && !fl_hit |=> $stable(count));
endmodule

// File: tb/sim_tx_burst_tracker.sv
module sim_tx_burst_tracker;
  localparam int ID_W = 8, PRI_W = 2, LEN_W = 21, TAG_W = 4, SEG_W = 9;

  typedef struct packed {
    logic [PRI_W-1:0] pri;
    logic [ID_W-1:0]  src;
    logic [ID_W-1:0]  dst;
    logic [SEG_W-1:0] bytes;
    logic [TAG_W-1:0] tag;
  } pkt_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_valid = 0, flush_req = 0, pkt_ready = 1, rsp_valid = 0, rsp_err = 0;
  logic peer_busy = 0, peer_grab = 0;
  logic [LEN_W-1:0] desc_len = '0;
  logic [ID_W-1:0]  desc_src = '0, desc_dst = '0, flush_src = '0, peer_src = '0, peer_dst = '0;
  logic [PRI_W-1:0] desc_pri = '0;
  logic [TAG_W-1:0] rsp_tag = '0;
  logic desc_ready, flush_busy, pkt_valid, done, done_err, proto_err, hold_busy, hold_grab;
  logic [TAG_W-1:0] pkt_tag;
  logic [SEG_W-1:0] pkt_bytes;
  logic [ID_W-1:0]  pkt_src, pkt_dst, hold_src, hold_dst;
  logic [PRI_W-1:0] pkt_pri;

  int total = 0, bad = 0, cyc = 0, exp_tag = 0;
  int done_n = 0, perr_n = 0, grab_n = 0;
  logic last_done_err = 0;
  pkt_t exp_q[$];
  logic [TAG_W-1:0] issued_q[$];
  int hs_cyc[$];
  bit finished = 0;

  always #10 clk = ~clk;

  tx_burst_tracker u0 (.*);

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (pkt_valid && pkt_ready) begin
      pkt_t e;
      if (exp_q.size() == 0) check(0, "R1 unexpected packet", int'(pkt_bytes), 0);
      else begin
        e = exp_q.pop_front();
        check(pkt_bytes == e.bytes, "R1 bytes", int'(pkt_bytes), int'(e.bytes));
        check(pkt_src == e.src && pkt_dst == e.dst && pkt_pri == e.pri, "R1 ids",
              int'({pkt_pri, pkt_src, pkt_dst}), int'({e.pri, e.src, e.dst}));
        check(pkt_tag == e.tag, "R3 tag", int'(pkt_tag), int'(e.tag));
      end
      issued_q.push_back(pkt_tag);
      hs_cyc.push_back(cyc);
    end
    if (done) begin done_n++; last_done_err = done_err; end
    if (proto_err) perr_n++;
    if (hold_grab) grab_n++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_xfer(input int len, input int src, input int dst, input int pri);
    pkt_t e;
    int r = len;
    while (r > 0) begin
      e.bytes = SEG_W'(r > 256 ? 256 : r);
      e.src = ID_W'(src); e.dst = ID_W'(dst); e.pri = PRI_W'(pri);
      e.tag = TAG_W'(exp_tag);
      exp_tag = (exp_tag + 1) % 16;
      exp_q.push_back(e);
      r -= 256;
    end
  endtask

  task automatic push_desc(input int len, input int src, input int dst, input int pri);
    @(posedge clk); #2;
    desc_valid = 1; desc_len = LEN_W'(len); desc_src = ID_W'(src);
    desc_dst = ID_W'(dst); desc_pri = PRI_W'(pri);
    @(negedge clk);
    while (!desc_ready) @(negedge clk);
    @(posedge clk); #2;
    desc_valid = 0;
  endtask

  task automatic send_rsp(input int tag, input bit err);
    @(posedge clk); #2;
    rsp_valid = 1; rsp_tag = TAG_W'(tag); rsp_err = err;
    @(posedge clk); #2;
    rsp_valid = 0; rsp_err = 0;
  endtask

  task automatic drain(input int err_at);
    int k = 0;
    while (issued_q.size() > 0) begin
      logic [TAG_W-1:0] t;
      t = issued_q.pop_front();
      send_rsp(int'(t), k == err_at);
      k++;
    end
  endtask

  task automatic wait_hs(input int n);
    while (hs_cyc.size() < n) @(negedge clk);
  endtask

  initial begin
    int n0, d0, p0, g0;
    tick(5);
    @(negedge clk);
    check(desc_ready && !pkt_valid && !hold_busy && !done && !flush_busy, "R10 reset state",
          int'({desc_ready, pkt_valid, hold_busy, done, flush_busy}), 16);
    rst_n = 1;
    tick(2);

    // R1 R2: 1000 bytes -> 256,256,256,232 back to back
    n0 = hs_cyc.size(); d0 = done_n;
    expect_xfer(1000, 1, 2, 1);
    push_desc(1000, 1, 2, 1);
    wait_hs(n0 + 4);
    check(hs_cyc[n0+3] - hs_cyc[n0] == 3, "R2 back to back", hs_cyc[n0+3] - hs_cyc[n0], 3);
    tick(5);
    check(exp_q.size() == 0, "R1 packet count", exp_q.size(), 0);
    check(done_n == d0, "R4 no done before responses", done_n, d0);
    p0 = perr_n;
    send_rsp(9, 0);
    tick(1);
    check(perr_n == p0 + 1, "R5 unknown tag flagged", perr_n, p0 + 1);
    check(done_n == d0, "R5 unknown tag ignored", done_n, d0);
    drain(1);
    tick(3);
    check(done_n == d0 + 1, "R4 done pulse", done_n, d0 + 1);
    check(last_done_err == 1, "R4 error flag", int'(last_done_err), 1);

    // R3: 17 packets, 17th reuses the first tag
    n0 = hs_cyc.size(); d0 = done_n;
    expect_xfer(4352, 5, 6, 0);
    push_desc(4352, 5, 6, 0);
    expect_xfer(10, 9, 9, 3);
    push_desc(10, 9, 9, 3);
    wait_hs(n0 + 16);
    tick(8);
    check(hs_cyc.size() == n0 + 16, "R3 stall at 16 outstanding", hs_cyc.size(), n0 + 16);
    @(negedge clk);
    check(hold_src == 5, "R4 next descriptor held back", int'(hold_src), 5);
    begin
      logic [TAG_W-1:0] t;
      t = issued_q.pop_front();
      send_rsp(int'(t), 0);
    end
    wait_hs(n0 + 17);
    drain(-1);
    tick(3);
    check(done_n == d0 + 1, "R4 17-packet transfer done", done_n, d0 + 1);
    check(last_done_err == 0, "R4 clean done", int'(last_done_err), 0);
    wait_hs(n0 + 18);
    drain(-1);
    tick(3);
    check(done_n == d0 + 2, "R9 queued descriptor follows", done_n, d0 + 2);

    // R6: peer holds the pair
    peer_src = 7; peer_dst = 8; peer_busy = 1;
    n0 = hs_cyc.size(); g0 = grab_n;
    expect_xfer(10, 7, 8, 2);
    push_desc(10, 7, 8, 2);
    tick(6);
    check(!hold_busy && hs_cyc.size() == n0, "R6 blocked by peer", int'(hold_busy), 0);
    peer_busy = 0;
    wait_hs(n0 + 1);
    check(grab_n == g0 + 1, "R11 single grab pulse", grab_n, g0 + 1);
    drain(-1);
    tick(3);

    // R7: peer grabbing same pair, then different pair
    peer_grab = 1;
    n0 = hs_cyc.size();
    expect_xfer(10, 7, 8, 1);
    push_desc(10, 7, 8, 1);
    tick(6);
    check(hs_cyc.size() == n0, "R7 yield to peer grab", hs_cyc.size(), n0);
    peer_grab = 0;
    wait_hs(n0 + 1);
    drain(-1);
    tick(3);
    peer_grab = 1; peer_dst = 9;
    n0 = hs_cyc.size();
    expect_xfer(10, 7, 8, 1);
    push_desc(10, 7, 8, 1);
    tick(4);
    check(hs_cyc.size() == n0 + 1, "R7 other pair not blocked", hs_cyc.size(), n0 + 1);
    peer_grab = 0;
    drain(-1);
    tick(3);

    // R8 R9: flush with full queue behind an active transfer
    pkt_ready = 0; d0 = done_n;
    expect_xfer(10, 1, 1, 0);
    push_desc(10, 1, 1, 0);
    expect_xfer(20, 2, 2, 0);
    push_desc(20, 2, 2, 0);
    push_desc(30, 1, 3, 0);
    expect_xfer(40, 2, 4, 0);
    push_desc(40, 2, 4, 0);
    expect_xfer(50, 3, 5, 0);
    push_desc(50, 3, 5, 0);
    @(negedge clk);
    check(!desc_ready, "R9 full queue", int'(desc_ready), 0);
    @(posedge clk); #2;
    flush_req = 1; flush_src = 1;
    @(posedge clk); #2;
    flush_req = 0;
    @(negedge clk);
    check(flush_busy && !desc_ready, "R8 flush busy", int'({flush_busy, desc_ready}), 2);
    while (flush_busy) @(negedge clk);
    check(hold_busy && hold_src == 1, "R8 active transfer kept", int'(hold_src), 1);
    check(desc_ready, "R8 slot freed", int'(desc_ready), 1);
    @(posedge clk); #2;
    pkt_ready = 1;
    while (exp_q.size() > 0 || issued_q.size() > 0) begin
      if (issued_q.size() > 0) drain(-1);
      else tick(1);
    end
    tick(4);
    check(done_n == d0 + 4, "R8 matching entry removed", done_n, d0 + 4);
    check(!hold_busy, "R8 idle after queue drained", int'(hold_busy), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule